// File: doc/BRIEF.md
# Quadword Multiply-by-Ten Unit

This unit executes a family of four vector instructions that multiply an unsigned 128-bit operand by ten. Two independent options modify the basic operation. The first adds one decimal digit, taken from a second operand, into the product. The second discards the 128-bit product and returns only the overflow above bit 127, which fits in four bits. The unit shares its opcode space with vector add instructions, which another unit handles. The record bit of the instruction word decides which of the two units claims the instruction.

Each cycle the issue logic may present an instruction word, a valid strobe and both source operands. The unit decodes the variant and checks the reserved field. It then forms the product from shifts and adds over two 64-bit halves in a two-stage pipeline. The low half is computed in the first stage, and its carry feeds the high half in the second stage. Two cycles after issue the unit raises a valid strobe along with either the result or an illegal-instruction flag. The result, flag and strobe stay in program order.

Top module: `mul10_quad_unit`

## Requirements
- R1: With sub-opcode 8 (instr[10:6]), the result is the low 128 bits of src_a × 10, with src_a treated as unsigned.
- R2: With sub-opcode 9, the result is the low 128 bits of src_a × 10 + src_b[3:0]. Only those four bits of src_b are used, and a digit above 9 gives an undefined result.
- R3: With sub-opcode 0, the result holds the bits of src_a × 10 above bit 127 in result[3:0], and result[127:4] is zero.
- R4: With sub-opcode 1, the result holds the bits of src_a × 10 + src_b[3:0] above bit 127 in result[3:0], and result[127:4] is zero.
- R5: An instruction is claimed only when the record bit instr[0] is 1. A word with instr[0] = 0 belongs to the add unit and produces no out_valid.
- R6: A claimed word is a recognised encoding when all of the following hold: instr[31:26] = 4, instr[5:1] = 0, and instr[10:6] is one of 0, 1, 8 or 9. For sub-opcodes 8 and 0, src_b is ignored.
- R7: For sub-opcodes 8 and 0, a non-zero instr[15:11] makes the instruction illegal. For sub-opcodes 9 and 1, that field names the second source and may be any value.
- R8: A claimed word that is illegal or unrecognised raises out_valid with out_illegal = 1 and out_result = 0.
- R9: Every claimed instruction gives exactly one out_valid, two clock edges after it is sampled. Back-to-back issue is accepted every cycle.
- R10: During and after reset, and with no result present, out_valid, out_illegal and out_result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction issue strobe |
| instr | input | 32 | Instruction word |
| src_a | input | 128 | Operand multiplied by ten |
| src_b | input | 128 | Operand supplying the carry-in digit |
| out_valid | output | 1 | Result or exception present |
| out_illegal | output | 1 | Instruction is illegal |
| out_result | output | 128 | Product or overflow digit |

## Verification
A wrong carry between the two halves shows up at the ports as a wrong upper doubleword, or a wrong overflow digit, on the second edge after issue. Operands near the all-ones value and near a power of two make that carry non-zero. A decode or reserved-field error shows up at the same edge as a wrong illegal flag, or as a strobe that is missing or should not be there. A pipeline-valid error shows up as a lost or extra strobe in a back-to-back stream. The bench compares every output on every cycle, so each of these faults is caught within two cycles of the instruction that triggers it.

// File: rtl/mul10_quad_unit.sv
module mul10_quad_unit #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  output logic          out_valid,
  output logic          out_illegal,
  output logic [DW-1:0] out_result
);
  localparam int HW   = DW / 2;
  localparam int DIGW = 4;
  localparam int SW   = HW + DIGW;
  localparam logic [5:0] PRIMARY = 6'd4;

  wire [4:0] sub     = instr[10:6];
  wire       claim   = in_valid & instr[0];
  wire       known   = (instr[31:26] == PRIMARY) && (instr[5:1] == 5'd0) &&
                       !sub[4] && (sub[2:1] == 2'b00);
  wire       ext     = sub[0];
  wire       car     = ~sub[3];
  wire       bad     = ~known | (~ext & (|instr[15:11]));
  wire [DIGW-1:0] cin = ext ? src_b[DIGW-1:0] : '0;

  wire [SW-1:0] lo_x   = {{DIGW{1'b0}}, src_a[HW-1:0]};
  wire [SW-1:0] lo_sum = (lo_x << 3) + (lo_x << 1) + {{HW{1'b0}}, cin};

  logic          s1_v, s1_bad, s1_car;
  logic [HW-1:0] s1_lo, s1_hia;
  logic [DIGW-1:0] s1_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_bad <= 1'b0;
      s1_car <= 1'b0;
      s1_lo  <= '0;
      s1_hia <= '0;
      s1_c   <= '0;
    end else begin
      s1_v   <= claim;
      s1_bad <= bad;
      s1_car <= car;
      s1_lo  <= lo_sum[HW-1:0];
      s1_c   <= lo_sum[SW-1:HW];
      s1_hia <= src_a[DW-1:HW];
    end
  end

  wire [SW-1:0] hi_x   = {{DIGW{1'b0}}, s1_hia};
  wire [SW-1:0] hi_sum = (hi_x << 3) + (hi_x << 1) + {{HW{1'b0}}, s1_c};

  logic o_car;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
      o_car       <= 1'b0;
    end else begin
      out_valid   <= s1_v;
      out_illegal <= s1_v & s1_bad;
      o_car       <= s1_v & s1_car;
      if (!s1_v || s1_bad)
        out_result <= '0;
      else if (s1_car)
        out_result <= {{(DW-DIGW){1'b0}}, hi_sum[SW-1:HW]};
      else
        out_result <= {hi_sum[HW-1:0], s1_lo};
    end
  end

  a_r9_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2) && $past(instr[0], 2));

  a_r5_rc_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !instr[0]) |-> ##2 !out_valid);

  a_r8_illegal_blank: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_valid && out_result == '0));

  a_r3_narrow_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal && o_car) |-> (out_result[DW-1:DIGW] == '0));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_illegal && out_result == '0));
endmodule

// File: tb/mul10_quad_unit_tb_top.sv
`timescale 1ns/1ps
module mul10_quad_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic         out_valid, out_illegal;
  logic [127:0] out_result;

  always #2.5 clk = ~clk;

  mul10_quad_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .out_illegal(out_illegal), .out_result(out_result)
  );

  int checks = 0;
  int fails  = 0;

  logic         m1_v = 0, m1_ill = 0, m2_v = 0, m2_ill = 0;
  logic [127:0] m1_res = '0, m2_res = '0;
  string        m1_tag = "", m2_tag = "";

  function automatic logic [31:0] mk(input int sub, input int rb, input bit rc);
    mk = {6'd4, 5'd3, 5'd7, rb[4:0], sub[4:0], 5'd0, rc};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] w, input logic [127:0] a,
                      input logic [127:0] b, input string tag);
    bit claim, legal, addd, retc;
    logic [131:0] p;
    logic [127:0] r;
    in_valid = v; instr = w; src_a = a; src_b = b;
    @(posedge clk);
    #1;
    claim = v && w[0];
    legal = 0; addd = 0; retc = 0;
    if (w[31:26] == 6'd4 && w[5:1] == 5'd0) begin
      case (int'(w[10:6]))
        8: begin legal = (w[15:11] == 0); end
        9: begin legal = 1; addd = 1; end
        0: begin legal = (w[15:11] == 0); retc = 1; end
        1: begin legal = 1; addd = 1; retc = 1; end
        default: legal = 0;
      endcase
    end
    p = {4'd0, a} * 132'd10 + (addd ? {128'd0, b[3:0]} : 132'd0);
    r = !legal ? 128'd0 : (retc ? {124'd0, p[131:128]} : p[127:0]);
    m2_v = m1_v; m2_ill = m1_ill; m2_res = m1_res; m2_tag = m1_tag;
    m1_v = claim; m1_ill = claim && !legal; m1_res = claim ? r : 128'd0; m1_tag = tag;
    check({m2_tag, " R9 valid"}, {127'd0, out_valid}, {127'd0, m2_v});
    check({m2_tag, " R8 illegal"}, {127'd0, out_illegal}, {127'd0, m2_ill});
    check({m2_tag, " result"}, out_result, m2_res);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, '0, '0, "R10 idle");
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL R9 watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [127:0] ones;
    ones = '1;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset valid", {127'd0, out_valid}, 128'd0);
    check("R10 reset result", out_result, 128'd0);
    rst_n = 1'b1;
    idle(2);
    step(1, mk(8, 0, 1), 128'h1234_5678, '0, "R1 small");
    step(1, mk(8, 0, 1), ones, '0, "R1 wrap");
    step(1, mk(8, 0, 1), 128'h0000_0000_0000_0000_1999_9999_9999_999A, '0, "R1 half carry");
    step(1, mk(8, 0, 1), 128'h8000_0000_0000_0000_ffff_ffff_ffff_ffff, ones, "R6 src_b ignored");
    step(1, mk(9, 5, 1), 128'd77, 128'hffff_0000_0000_0000_0000_0000_0000_0009, "R2 digit 9");
    step(1, mk(9, 31, 1), ones, 128'h5, "R2 wrap digit");
    step(1, mk(0, 0, 1), ones, '0, "R3 all ones");
    step(1, mk(0, 0, 1), 128'h8000_0000_0000_0000_0000_0000_0000_0000, '0, "R3 top bit");
    step(1, mk(0, 0, 1), 128'd12345, ones, "R3 zero carry");
    step(1, mk(1, 2, 1), ones, 128'h9, "R4 max");
    step(1, mk(1, 2, 1), 128'h1999_9999_9999_9999_9999_9999_9999_9999, 128'h6, "R4 edge");
    step(1, mk(8, 0, 0), 128'd5, '0, "R5 rc zero");
    step(1, mk(9, 4, 0), 128'd5, 128'd1, "R5 rc zero ext");
    step(1, mk(8, 3, 1), 128'd5, '0, "R7 reserved set");
    step(1, mk(0, 16, 1), 128'd5, '0, "R7 reserved set carry");
    step(1, mk(2, 0, 1), 128'd5, '0, "R6 bad sub");
    step(1, mk(8, 0, 1) ^ 32'h0400_0000, 128'd5, '0, "R6 bad primary");
    step(1, mk(8, 0, 1) | 32'h0000_0004, 128'd5, '0, "R6 bad low field");
    step(1, mk(0, 0, 1), 128'd1, '0, "R9 gap before");
    idle(1);
    for (int i = 0; i < 200; i++) begin
      int s;
      case (i % 6)
        0: s = 8; 1: s = 9; 2: s = 0; 3: s = 1; 4: s = 3; default: s = 8;
      endcase
      step(1, mk(s, (i % 4 == 0) ? i % 32 : 0, (i % 7) != 0),
           {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, 28'd0, 4'($urandom % 10)},
           "R9 stream");
    end
    idle(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule